// File: doc/BRIEF.md
# Control-Flow Next-Address Unit

This unit decides where instruction fetch goes after a control-flow instruction. Each cycle it takes the address of the current instruction, the 32-bit instruction word and the two source register values read for it. It returns the address to fetch next, whether that address departs from straight-line flow, and the register write-back that saves a return address. Non-control instructions simply advance by one word.

The unit is purely combinational and settles within the cycle in which the instruction is presented. A decoder sorts the instruction into one of nine control kinds. A condition evaluator tests the register operands for that kind. A target generator forms the fall-through, PC-relative, region-absolute and register-indirect addresses in parallel. The top level selects among them. The control kinds are: sequential, equal, not-equal, at-most-zero, above-zero, below-zero, at-least-zero, absolute jump and register jump. There are no states and no transitions. Field positions: opcode is bits 31:26, the first source field is bits 25:21, the second source field is bits 20:16, the destination field is bits 15:11, the function code is bits 5:0, the offset is bits 15:0 and the jump index is bits 25:0.

Top module: `npc_unit`

## Requirements
- R1: An instruction outside the control set yields next address = PC + 4, redirect 0, link enable 0 and link register 0. The control set is opcodes 000001 to 000111 as listed below, plus opcode 000000 with function 001000 or 001001. Under opcode 000001 it includes only second-source codes 00000, 00001, 10000 and 10001.
- R2: Opcode 000100 redirects when rs equals rt, and opcode 000101 redirects when they differ. The taken target is PC + 4 + (sign-extended bits 15:0 shifted left by 2). When not taken the next address is PC + 4.
- R3: Opcode 000110 redirects when rs, read as signed, is zero or negative. Opcode 000111 redirects when rs is strictly positive. Neither depends on rt. The target is formed as in R2.
- R4: Under opcode 000001, the code in bits 20:16 selects the test. Code 00000 tests rs < 0, code 00001 tests rs >= 0, code 10000 tests rs < 0 with link, and code 10001 tests rs >= 0 with link. All comparisons are signed. The target is formed as in R2.
- R5: The two linking zero-compare branches (codes 10000 and 10001) assert link enable only when taken. They then give link register 31 and link value PC + 4. When not taken, the link enable is 0 and the link register is 0.
- R6: Opcodes 000010 and 000011 jump to {(PC+4)[31:28], bits 25:0, 00}. Opcode 000011 also writes link value PC + 4 to register 31.
- R7: Opcode 000000 with function 001000 jumps to the rs value and writes no link.
- R8: Opcode 000000 with function 001001 jumps to the rs value. It writes link value PC + 4 to the register named in bits 15:11, including register 0.
- R9: Address arithmetic wraps modulo 2^32, and negative offsets move backwards.
- R10: Redirect is 1 exactly for a taken branch or any jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of first source register |
| rt_val_i | input | 32 | Value of second source register |
| next_pc_o | output | 32 | Address to fetch next |
| redirect_o | output | 1 | Next address departs from PC + 4 path |
| link_we_o | output | 1 | Return-address write enable |
| link_rd_o | output | 5 | Return-address destination register |
| link_val_o | output | 32 | Return-address value (PC + 4) |

## Verification
Each compare kind is driven with operand pairs on both sides of its decision. The pairs used are equal and unequal values, zero, one, the most negative value and minus one. These pairs separate signed from unsigned comparisons and strict from non-strict ones. Linking branches are driven both taken and not taken, which shows whether the link write depends on the outcome. Jumps use a PC whose increment crosses a region boundary, which shows which PC supplies the upper bits. Non-control opcodes and an unused zero-compare code show that only the defined encodings redirect.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam logic [5:0] OP_SPECIAL = 6'b000000;
    localparam logic [5:0] OP_REGIMM  = 6'b000001;
    localparam logic [5:0] OP_JABS    = 6'b000010;
    localparam logic [5:0] OP_JABSL   = 6'b000011;
    localparam logic [5:0] OP_BEQ     = 6'b000100;
    localparam logic [5:0] OP_BNE     = 6'b000101;
    localparam logic [5:0] OP_BLEZ    = 6'b000110;
    localparam logic [5:0] OP_BGTZ    = 6'b000111;

    localparam logic [5:0] FN_JREG    = 6'b001000;
    localparam logic [5:0] FN_JREGL   = 6'b001001;

    localparam logic [4:0] RI_LTZ     = 5'b00000;
    localparam logic [4:0] RI_GEZ     = 5'b00001;
    localparam logic [4:0] RI_LTZL    = 5'b10000;
    localparam logic [4:0] RI_GEZL    = 5'b10001;

    typedef enum logic [3:0] {
        CK_SEQ,
        CK_EQ,
        CK_NE,
        CK_LEZ,
        CK_GTZ,
        CK_LTZ,
        CK_GEZ,
        CK_JABS,
        CK_JREG
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e kind;
        logic      link;
        logic      link_from_rd;
    } ctl_dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [4:0] rtf_i,
    input  logic [5:0] funct_i,
    output ctl_dec_t   dec_o
);
    always_comb begin
        dec_o = '{kind: CK_SEQ, link: 1'b0, link_from_rd: 1'b0};
        unique case (opcode_i)
            OP_BEQ:   dec_o.kind = CK_EQ;
            OP_BNE:   dec_o.kind = CK_NE;
            OP_BLEZ:  dec_o.kind = CK_LEZ;
            OP_BGTZ:  dec_o.kind = CK_GTZ;
            OP_JABS:  dec_o.kind = CK_JABS;
            OP_JABSL: begin
                dec_o.kind = CK_JABS;
                dec_o.link = 1'b1;
            end
            OP_REGIMM: begin
                unique case (rtf_i)
                    RI_LTZ:  dec_o.kind = CK_LTZ;
                    RI_GEZ:  dec_o.kind = CK_GEZ;
                    RI_LTZL: begin
                        dec_o.kind = CK_LTZ;
                        dec_o.link = 1'b1;
                    end
                    RI_GEZL: begin
                        dec_o.kind = CK_GEZ;
                        dec_o.link = 1'b1;
                    end
                    default: dec_o.kind = CK_SEQ;
                endcase
            end
            OP_SPECIAL: begin
                unique case (funct_i)
                    FN_JREG:  dec_o.kind = CK_JREG;
                    FN_JREGL: begin
                        dec_o.kind         = CK_JREG;
                        dec_o.link         = 1'b1;
                        dec_o.link_from_rd = 1'b1;
                    end
                    default: dec_o.kind = CK_SEQ;
                endcase
            end
            default: dec_o.kind = CK_SEQ;
        endcase
    end

    // R5: only linking kinds may request a link write
    always_comb begin
        if (dec_o.link) begin
            p_link_kind_r5: assert (dec_o.kind inside {CK_LTZ, CK_GEZ, CK_JABS, CK_JREG})
                else $error("link requested by non-linking kind");
        end
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctl_kind_e        kind_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic             take_o
);
    logic neg;
    logic zero;

    assign neg  = opa_i[XLEN-1];
    assign zero = (opa_i == '0);

    always_comb begin
        unique case (kind_i)
            CK_EQ:   take_o = (opa_i == opb_i);
            CK_NE:   take_o = (opa_i != opb_i);
            CK_LEZ:  take_o = neg | zero;
            CK_GTZ:  take_o = ~neg & ~zero;
            CK_LTZ:  take_o = neg;
            CK_GEZ:  take_o = ~neg;
            CK_JABS: take_o = 1'b1;
            CK_JREG: take_o = 1'b1;
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN   = 32,
    parameter int IDX_W  = 26,
    parameter int OFF_W  = 16,
    parameter int ALIGN  = 2
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IDX_W-1:0] index_i,
    input  logic [XLEN-1:0]  reg_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  rel_o,
    output logic [XLEN-1:0]  abs_o,
    output logic [XLEN-1:0]  ind_o
);
    localparam int REGION_LO = IDX_W + ALIGN;
    localparam int EXT_W     = XLEN - OFF_W - ALIGN;
    localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN);

    logic [OFF_W-1:0] off;
    logic [XLEN-1:0]  off_bytes;

    assign off       = index_i[OFF_W-1:0];
    assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off, {ALIGN{1'b0}}};

    assign seq_o = pc_i + STEP;
    assign rel_o = seq_o + off_bytes;
    assign abs_o = {seq_o[XLEN-1:REGION_LO], index_i, {ALIGN{1'b0}}};
    assign ind_o = reg_i;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_AW   = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              redirect_o,
    output logic              link_we_o,
    output logic [REG_AW-1:0] link_rd_o,
    output logic [XLEN-1:0]   link_val_o
);
    localparam logic [REG_AW-1:0] LINK_IDX = REG_AW'(LINK_REG);
    localparam int REGION_LO = 28;

    ctl_dec_t        dec;
    logic            take;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] abs_pc;
    logic [XLEN-1:0] ind_pc;

    npc_decode u_decode (
        .opcode_i (instr_i[31:26]),
        .rtf_i    (instr_i[20:16]),
        .funct_i  (instr_i[5:0]),
        .dec_o    (dec)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .kind_i (dec.kind),
        .opa_i  (rs_val_i),
        .opb_i  (rt_val_i),
        .take_o (take)
    );

    npc_target #(.XLEN(XLEN)) u_target (
        .pc_i    (pc_i),
        .index_i (instr_i[25:0]),
        .reg_i   (rs_val_i),
        .seq_o   (seq_pc),
        .rel_o   (rel_pc),
        .abs_o   (abs_pc),
        .ind_o   (ind_pc)
    );

    always_comb begin
        unique case (dec.kind)
            CK_JABS: next_pc_o = abs_pc;
            CK_JREG: next_pc_o = ind_pc;
            CK_SEQ:  next_pc_o = seq_pc;
            default: next_pc_o = take ? rel_pc : seq_pc;
        endcase
    end

    assign redirect_o = take;
    assign link_we_o  = dec.link & take;
    assign link_rd_o  = !link_we_o ? '0 :
                        (dec.link_from_rd ? instr_i[15:11] : LINK_IDX);
    assign link_val_o = seq_pc;

    always_comb begin
        // R5: a link write never happens without the transfer being taken
        if (link_we_o) begin
            p_link_needs_taken_r5: assert (redirect_o)
                else $error("link write without redirect");
        end
        // R1: without redirect the fetch continues at the fall-through
        if (!redirect_o) begin
            p_fallthrough_r1: assert (next_pc_o == seq_pc)
                else $error("no redirect but next address not sequential");
        end
        // R10: non-control kinds never redirect
        if (dec.kind == CK_SEQ) begin
            p_seq_no_redirect_r10: assert (!redirect_o)
                else $error("sequential kind redirected");
        end
        // R3: a taken above-zero branch has a strictly positive operand
        if (dec.kind == CK_GTZ && redirect_o) begin
            p_gtz_positive_r3: assert (!rs_val_i[XLEN-1] && rs_val_i != '0)
                else $error("above-zero taken on non-positive operand");
        end
        // R6: absolute jumps stay in the region of the fall-through
        if (dec.kind == CK_JABS) begin
            p_region_kept_r6: assert (next_pc_o[XLEN-1:REGION_LO] == seq_pc[XLEN-1:REGION_LO])
                else $error("absolute jump left region");
        end
    end
endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] pc, ins, a, b;
    logic [31:0] nxt, lval;
    logic        red, we;
    logic [4:0]  rd;

    npc_unit u_npc_unit (
        .pc_i       (pc),
        .instr_i    (ins),
        .rs_val_i   (a),
        .rt_val_i   (b),
        .next_pc_o  (nxt),
        .redirect_o (red),
        .link_we_o  (we),
        .link_rd_o  (rd),
        .link_val_o (lval)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    function automatic logic [31:0] ei(input logic [5:0] op, input logic [4:0] s,
                                       input logic [4:0] t, input logic [15:0] im);
        return {op, s, t, im};
    endfunction

    function automatic logic [31:0] er(input logic [4:0] s, input logic [4:0] d,
                                       input logic [5:0] fn);
        return {6'd0, s, 5'd0, d, 5'd0, fn};
    endfunction

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] nxt;
        logic        red;
        logic        we;
        logic [4:0]  rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VT [NV] = '{
        // R2 equal / not equal
        '{32'h1000, ei(6'd4,5'd1,5'd2,16'd4),      32'd5, 32'd5, 32'h1014, 1'b1, 1'b0, 5'd0, 4'd2},
        '{32'h1000, ei(6'd4,5'd1,5'd2,16'd4),      32'd5, 32'd6, 32'h1004, 1'b0, 1'b0, 5'd0, 4'd2},
        '{32'h2000, ei(6'd5,5'd1,5'd2,16'hFFFE),   32'd5, 32'd6, 32'h1FFC, 1'b1, 1'b0, 5'd0, 4'd2},
        '{32'h2000, ei(6'd5,5'd1,5'd2,16'hFFFE),   32'd9, 32'd9, 32'h2004, 1'b0, 1'b0, 5'd0, 4'd2},
        // R3 at-most-zero / above-zero, rt value ignored
        '{32'h3000, ei(6'd6,5'd1,5'd0,16'd8),      32'd0, 32'd7, 32'h3024, 1'b1, 1'b0, 5'd0, 4'd3},
        '{32'h3000, ei(6'd6,5'd1,5'd0,16'd8),      32'd1, 32'd0, 32'h3004, 1'b0, 1'b0, 5'd0, 4'd3},
        '{32'h3000, ei(6'd7,5'd1,5'd0,16'd8),  32'h80000000, 32'd1, 32'h3004, 1'b0, 1'b0, 5'd0, 4'd3},
        '{32'h3000, ei(6'd7,5'd1,5'd0,16'd8),      32'd7, 32'd0, 32'h3024, 1'b1, 1'b0, 5'd0, 4'd3},
        // R4 zero-compare group selected by second source field
        '{32'h4000, ei(6'd1,5'd1,5'd0,16'd1),  32'hFFFFFFFF, 32'd0, 32'h4008, 1'b1, 1'b0, 5'd0, 4'd4},
        '{32'h4000, ei(6'd1,5'd1,5'd0,16'd1),      32'd0, 32'd0, 32'h4004, 1'b0, 1'b0, 5'd0, 4'd4},
        '{32'h4000, ei(6'd1,5'd1,5'd1,16'd1),      32'd0, 32'd0, 32'h4008, 1'b1, 1'b0, 5'd0, 4'd4},
        '{32'h4000, ei(6'd1,5'd1,5'd1,16'd1),  32'h80000000, 32'd0, 32'h4004, 1'b0, 1'b0, 5'd0, 4'd4},
        // R5 linking branches taken / not taken
        '{32'h4000, ei(6'd1,5'd1,5'd16,16'd1), 32'hFFFFFFFF, 32'd0, 32'h4008, 1'b1, 1'b1, 5'd31, 4'd5},
        '{32'h4000, ei(6'd1,5'd1,5'd17,16'd1), 32'hFFFFFFFB, 32'd0, 32'h4004, 1'b0, 1'b0, 5'd0, 4'd5},
        '{32'h4000, ei(6'd1,5'd1,5'd17,16'd1),     32'd3, 32'd0, 32'h4008, 1'b1, 1'b1, 5'd31, 4'd5},
        '{32'h4000, ei(6'd1,5'd1,5'd16,16'd1),     32'd3, 32'd0, 32'h4004, 1'b0, 1'b0, 5'd0, 4'd5},
        // R6 absolute jumps, region from PC + 4
        '{32'hA0000100, {6'd2, 26'd32},            32'd0, 32'd0, 32'hA0000080, 1'b1, 1'b0, 5'd0, 4'd6},
        '{32'h5FFFFFFC, {6'd3, 26'h3FFFFFF},       32'd0, 32'd0, 32'h6FFFFFFC, 1'b1, 1'b1, 5'd31, 4'd6},
        // R7 register jump
        '{32'h0700, er(5'd3, 5'd31, 6'h08),    32'h00400020, 32'd0, 32'h00400020, 1'b1, 1'b0, 5'd0, 4'd7},
        // R8 register jump with link into rd
        '{32'h0800, er(5'd3, 5'd7, 6'h09),     32'h00001234, 32'd0, 32'h00001234, 1'b1, 1'b1, 5'd7, 4'd8},
        // R1 non-control: add, unused zero-compare code, load
        '{32'h0900, 32'h00641020,                  32'd1, 32'd1, 32'h0904, 1'b0, 1'b0, 5'd0, 4'd1},
        '{32'h4000, ei(6'd1,5'd1,5'd2,16'd1),  32'hFFFFFFFF, 32'd0, 32'h4004, 1'b0, 1'b0, 5'd0, 4'd1},
        '{32'h0A00, ei(6'h23,5'd1,5'd2,16'd8),     32'd0, 32'd0, 32'h0A04, 1'b0, 1'b0, 5'd0, 4'd1},
        // R9 wraparound past the top of the address space
        '{32'hFFFFFFF8, ei(6'd4,5'd1,5'd2,16'd4),  32'd2, 32'd2, 32'h0000000C, 1'b1, 1'b0, 5'd0, 4'd9}
    };

    task automatic chk(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [31:0] i,
                         input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        #1;
        pc = p; ins = i; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic check_all(input int req, input logic [31:0] enxt, input logic ered,
                             input logic ewe, input logic [4:0] erd);
        chk("next address", req, nxt, enxt);
        // R10: redirect flags exactly taken branches and jumps
        chk("redirect", req, {31'd0, red}, {31'd0, ered});
        chk("link enable", req, {31'd0, we}, {31'd0, ewe});
        chk("link register", req, {27'd0, rd}, {27'd0, erd});
        if (ewe) chk("link value", req, lval, pc + 32'd4);
    endtask

    initial begin
        pc = '0; ins = '0; a = '0; b = '0;
        // R1: all-zero instruction (shift form) on zero inputs is sequential
        @(negedge clk);
        check_all(1, 32'h4, 1'b0, 1'b0, 5'd0);

        for (int k = 0; k < NV; k++) begin
            apply(VT[k].pc, VT[k].ins, VT[k].a, VT[k].b);
            check_all(int'(VT[k].req), VT[k].nxt, VT[k].red, VT[k].we, VT[k].rd);
        end

        // R8: link into register 0 is still requested
        apply(32'h0C00, er(5'd4, 5'd0, 6'h09), 32'h00002000, 32'd0);
        check_all(8, 32'h00002000, 1'b1, 1'b1, 5'd0);
        // R7: destination field of a non-linking register jump is ignored
        apply(32'h0C00, er(5'd4, 5'd12, 6'h08), 32'h00003000, 32'd0);
        check_all(7, 32'h00003000, 1'b1, 1'b0, 5'd0);
        // R1: opcode 0 with another function code stays sequential
        apply(32'h0D00, er(5'd4, 5'd12, 6'h0A), 32'h00003000, 32'd0);
        check_all(1, 32'h0D04, 1'b0, 1'b0, 5'd0);
        // R9: backward offset of minus one word lands on the branch itself
        apply(32'h0100, ei(6'd4,5'd1,5'd2,16'hFFFF), 32'd0, 32'd0);
        check_all(9, 32'h0100, 1'b1, 1'b0, 5'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R0 watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule